// File: doc/BRIEF.md
# Watchdog Timer with Persistent Overflow Flag

This block is a watchdog timer controlled through one overloaded register bit. Writing 1 to the bit restarts the timeout count. Writing 0 leaves the count alone and clears an event flag raised by an external clock-loss monitor (`pll_fall`). Reading the bit returns that event flag. If firmware lets the count run out, the block raises a reset request for one cycle. It also sets an overflow status flag.

The overflow flag sits in an always-on domain and has its own power-up reset (`por_n`). The core reset (`rst_n`) is the one the reset sequencer asserts after a watchdog request, and it does not touch this flag. Boot firmware can therefore read the flag and tell a watchdog recovery apart from a power fault. Firmware clears the flag by writing 0 to it. The external reset input also clears it, and keeps it clear for as long as that input is high.

The counting logic is a three-state machine:
- `ST_COUNT` counts cycles. A kick (control write of 1) keeps it in `ST_COUNT` with the count at zero. Reaching the terminal count with no kick in that cycle moves it to `ST_FIRE`.
- `ST_FIRE` lasts exactly one cycle and drives the reset request. It always moves on to `ST_HOLD`.
- `ST_HOLD` stays quiet until a kick returns it to `ST_COUNT`.
- An active `rst_n` forces the machine to `ST_COUNT` with the count at zero.

Top module: `wdog_sticky_top`

## Requirements
- R1: A control write of 1 (`ctl_wr_en`=1, `ctl_wr_data`=1) restarts the count. With no further kick, `rst_req` is high in exactly the cycle that follows the TIMEOUT_CYC-th rising edge after the kick edge. It is low in every cycle before that one.
- R2: A control write of 0 clears the event flag and does not change when the timeout expires.
- R3: A `pll_fall` pulse sets the event flag. `ctl_rd_data` always shows the flag's value, from the cycle after the setting edge onward.
- R4: If `pll_fall` and a control write of 0 arrive in the same cycle, the event flag ends up set.
- R5: `rst_req` is high for a single cycle per overflow (`ST_FIRE`). No further request follows until a kick or a core reset (`ST_HOLD`).
- R6: An overflow sets `ovf_flag`, one cycle after `rst_req` rises.
- R7: Asserting `rst_n` leaves `ovf_flag` unchanged.
- R8: A status write of 0 (`sts_wr_en`=1, `sts_wr_data`=0) clears `ovf_flag`. A status write of 1 has no effect. If a status write of 0 lands in the `rst_req` cycle, the flag still ends up set.
- R9: While `ext_reset` is high, `ovf_flag` is cleared and stays clear. This holds over any set or status write.
- R10: `por_n` low clears `ovf_flag`. `rst_n` low clears the event flag and `rst_req`.
- R11: After `rst_n` is released, the first timeout arrives on the TIMEOUT_CYC-th rising edge after the release. Release counts the same as a kick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, asynchronous, active low |
| por_n | input | 1 | Always-on domain power-up reset, active low |
| ext_reset | input | 1 | External reset level; high clears the overflow flag |
| ctl_wr_en | input | 1 | Control bit write strobe |
| ctl_wr_data | input | 1 | Control bit write value (1 kicks, 0 clears event flag) |
| ctl_rd_data | output | 1 | Control bit read value: the event flag |
| pll_fall | input | 1 | Clock-loss event pulse from the monitor |
| sts_wr_en | input | 1 | Overflow status write strobe |
| sts_wr_data | input | 1 | Overflow status write value (0 clears) |
| ovf_flag | output | 1 | Persistent overflow status |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
An off-by-one in the counter or in the restart path moves the `rst_req` pulse by a cycle. The bench pins that pulse to one exact cycle after each kick, after a mid-count clear, and after a core reset release. A machine stuck in `ST_FIRE`, or one that leaves `ST_HOLD` without a kick, shows up as a second request during the quiet window, which spans three timeouts. A flag wired to the wrong reset shows up at the port as soon as `rst_n` or `por_n` is pulsed. A wrong set/clear priority shows up on the edge right after a same-cycle collision.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HOLD  = 2'd2
    } wdog_state_e;

endpackage

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic req
);

    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    wdog_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_COUNT: begin
                if (kick) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_FIRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_FIRE: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
            ST_HOLD: begin
                cnt_d = '0;
                if (kick) state_d = ST_COUNT;
            end
            default: begin
                state_d = ST_COUNT;
                cnt_d   = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        req = (state_q == ST_FIRE);
    end

    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !kick) |=> !req);

    p_kick_defers_r1: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !req);

endmodule

// File: rtl/wdog_evt_flag.sv
module wdog_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_set,
    input  logic evt_clr,
    output logic evt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       evt_q <= 1'b0;
        else if (evt_set) evt_q <= 1'b1;
        else if (evt_clr) evt_q <= 1'b0;
    end

    p_evt_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set |=> evt_q);

    p_evt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !evt_set) |=> !evt_q);

endmodule

// File: rtl/wdog_aon_flag.sv
module wdog_aon_flag (
    input  logic clk,
    input  logic por_n,
    input  logic ext_clr,
    input  logic ovf_set,
    input  logic fw_clr,
    output logic flag_q
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       flag_q <= 1'b0;
        else if (ext_clr) flag_q <= 1'b0;
        else if (ovf_set) flag_q <= 1'b1;
        else if (fw_clr)  flag_q <= 1'b0;
    end

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!por_n)
        (ovf_set && !ext_clr) |=> flag_q);

    p_ext_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
        ext_clr |=> !flag_q);

    p_fw_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        (fw_clr && !ovf_set) |=> !flag_q);

    p_flag_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && !ext_clr && !fw_clr) |=> flag_q);

endmodule

// File: rtl/wdog_sticky_top.sv
module wdog_sticky_top #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic ext_reset,
    input  logic ctl_wr_en,
    input  logic ctl_wr_data,
    output logic ctl_rd_data,
    input  logic pll_fall,
    input  logic sts_wr_en,
    input  logic sts_wr_data,
    output logic ovf_flag,
    output logic rst_req
);

    logic kick;
    logic evt_clr;
    logic fw_clr;

    assign kick    = ctl_wr_en &  ctl_wr_data;
    assign evt_clr = ctl_wr_en & ~ctl_wr_data;
    assign fw_clr  = sts_wr_en & ~sts_wr_data;

    wdog_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (kick),
        .req   (rst_req)
    );

    wdog_evt_flag u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (pll_fall),
        .evt_clr (evt_clr),
        .evt_q   (ctl_rd_data)
    );

    wdog_aon_flag u_aon (
        .clk     (clk),
        .por_n   (por_n),
        .ext_clr (ext_reset),
        .ovf_set (rst_req),
        .fw_clr  (fw_clr),
        .flag_q  (ovf_flag)
    );

endmodule

// File: tb/sim_wdog_sticky_top.sv
module sim_wdog_sticky_top;

    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_n = 1'b0;
    logic ext_reset = 1'b0;
    logic ctl_wr_en = 1'b0;
    logic ctl_wr_data = 1'b0;
    logic pll_fall = 1'b0;
    logic sts_wr_en = 1'b0;
    logic sts_wr_data = 1'b0;
    logic ctl_rd_data, ovf_flag, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_sticky_top #(.TIMEOUT_CYC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .ext_reset(ext_reset),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .pll_fall(pll_fall), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .ovf_flag(ovf_flag), .rst_req(rst_req)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic ctl_write(input logic v);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_data = 1'b0;
    endtask

    task automatic sts_write(input logic v);
        sts_wr_en = 1'b1; sts_wr_data = v;
        @(negedge clk);
        sts_wr_en = 1'b0; sts_wr_data = 1'b0;
    endtask

    // Caller stands at the negedge after edge n0 counted from a zero count
    task automatic expect_timeout(input string req, input int n0);
        repeat (T - 1 - n0) @(negedge clk);
        check(req, "rst_req before terminal edge", rst_req, 1'b0);
        @(negedge clk);
        check(req, "rst_req at terminal edge", rst_req, 1'b1);
    endtask

    task automatic t_reset_state();
        check("R10", "rst_req in reset", rst_req, 1'b0);
        check("R10", "event flag in reset", ctl_rd_data, 1'b0);
        check("R10", "ovf_flag after power-up", ovf_flag, 1'b0);
    endtask

    task automatic t_kick_timeout();
        ctl_write(1'b1);
        repeat (10) @(negedge clk);
        ctl_write(1'b1);              // second kick restarts the count
        expect_timeout("R1", 0);
        @(negedge clk);
        check("R5", "rst_req one cycle only", rst_req, 1'b0);
        check("R6", "ovf_flag set after request", ovf_flag, 1'b1);
    endtask

    task automatic t_hold_quiet();
        bit seen = 1'b0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
        check("R5", "no request while holding", seen, 1'b0);
    endtask

    task automatic t_clear_no_effect();
        pll_fall = 1'b1; @(negedge clk); pll_fall = 1'b0;
        check("R3", "read shows event", ctl_rd_data, 1'b1);
        ctl_write(1'b1);
        ctl_write(1'b0);              // mid-count clear, now after edge 1
        check("R2", "write 0 clears event", ctl_rd_data, 1'b0);
        expect_timeout("R2", 1);
        @(negedge clk);
    endtask

    task automatic t_event_race();
        pll_fall = 1'b1; ctl_wr_en = 1'b1; ctl_wr_data = 1'b0;
        @(negedge clk);
        pll_fall = 1'b0; ctl_wr_en = 1'b0;
        check("R4", "set beats clear", ctl_rd_data, 1'b1);
        repeat (2) @(negedge clk);
        check("R3", "event flag holds", ctl_rd_data, 1'b1);
    endtask

    task automatic t_core_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", "ovf_flag kept over core reset", ovf_flag, 1'b1);
        check("R10", "event cleared by core reset", ctl_rd_data, 1'b0);
        check("R10", "rst_req low in core reset", rst_req, 1'b0);
        rst_n = 1'b1;
        expect_timeout("R11", 0);
        @(negedge clk);
    endtask

    task automatic t_fw_clear();
        sts_write(1'b1);
        check("R8", "status write 1 ignored", ovf_flag, 1'b1);
        sts_write(1'b0);
        check("R8", "status write 0 clears", ovf_flag, 1'b0);
        ctl_write(1'b1);
        expect_timeout("R1", 0);
        sts_write(1'b0);              // lands in the request cycle
        check("R8", "set beats firmware clear", ovf_flag, 1'b1);
    endtask

    task automatic t_ext_reset();
        ext_reset = 1'b1;
        @(negedge clk);
        check("R9", "ext_reset clears flag", ovf_flag, 1'b0);
        ctl_write(1'b1);
        repeat (T + 2) @(negedge clk);
        check("R9", "flag held clear over overflow", ovf_flag, 1'b0);
        ext_reset = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", "flag clear after release", ovf_flag, 1'b0);
    endtask

    task automatic t_por();
        ctl_write(1'b1);
        expect_timeout("R1", 0);
        @(negedge clk);
        check("R6", "ovf_flag set again", ovf_flag, 1'b1);
        por_n = 1'b0;
        @(negedge clk);
        check("R10", "por_n clears flag", ovf_flag, 1'b0);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        por_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_kick_timeout();
        t_hold_quiet();
        t_clear_no_effect();
        t_event_race();
        t_core_reset();
        t_fw_clear();
        t_ext_reset();
        t_por();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

endmodule